// File: doc/BRIEF.md
# Memory-to-Stream Burst Read Engine

This block pulls data out of a ring buffer in system memory and replays it as a stream. It drives the read-address and read-data channels of an AXI memory-mapped master port. Every request is a fixed incrementing burst of 16 beats of 64 bits, so each request covers 128 bytes. The returned beats land in an internal FIFO, and the FIFO drains through an AXI4-Stream master. A request goes out only when the FIFO already has room for a whole burst. Because that room is reserved up front, the read-data channel never has to be throttled.

The buffer has two plain configuration inputs, a base byte address and a wrap index. A burst index picks which 128-byte slot of the ring is fetched next. The index steps after each completed burst and drops back to zero once it reaches the wrap index. The index is also a status output, so software can see how far through the ring the engine has read.

Back-pressure rules: on the stream side an entry leaves the FIFO only on a cycle where `m_tvalid` and `m_tready` are both high. While `m_tready` is low, the data is held and no entry is lost. A stalled stream fills the FIFO and then stops new read requests. Requests resume once 16 entries of space are free again. On the memory side the slave may stall both `ar_ready` and `r_valid` for any number of cycles.

Top module: `mem_stream_reader`

## Requirements
- R1: A read request (`ar_valid` rising) is raised only when the FIFO holds no more than FIFO_DEPTH-16 entries. With the default depth of 32 and a stalled stream, no more than two bursts are requested. After that, a third is requested only once 16 entries have been popped, and never after only 15.
- R2: While `ar_valid` is high, `ar_len` is 15 (16 beats), `ar_size` is 3 (8-byte beats) and `ar_burst` is 2'b01 (incrementing).
- R3: The request address equals `base_addr + burst_idx*128`, taken from both values on the cycle before `ar_valid` rises. It is held until the request is accepted.
- R4: The burst index advances on the cycle that accepts the beat carrying `r_last`. If the index is equal to or greater than `wrap_idx`, it becomes 0. Otherwise it becomes index+1. With `wrap_idx`=0 it stays at 0.
- R5: `burst_idx` always shows the current burst index, which counts the bursts completed since reset, modulo `wrap_idx`+1.
- R6: At most one burst is outstanding. `ar_valid` stays low from the accepted request until the `r_last` beat has been accepted.
- R7: `r_ready` is high exactly while a burst is outstanding: from the cycle after the request is accepted through the cycle that accepts `r_last`.
- R8: Once raised, `ar_valid` and `ar_addr` hold steady until `ar_ready` is sampled high.
- R9: `m_tvalid` is high whenever the FIFO is non-empty. The beats appear on `m_tdata` in the order they were received. While `m_tvalid` is high and `m_tready` is low, `m_tdata` holds steady.
- R10: Under any pattern of `m_tready`, every received beat is delivered exactly once and the FIFO never exceeds its depth.
- R11: While `rst_n` (synchronous, active low) is sampled low, the FIFO empties, the burst index clears and `ar_valid`, `r_ready` and `m_tvalid` go low by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_addr | input | ADDR_W | Byte address of slot 0 of the ring buffer |
| wrap_idx | input | IDX_W | Last burst index before the index returns to 0 |
| burst_idx | output | IDX_W | Current burst index (status) |
| ar_addr | output | ADDR_W | Read request byte address |
| ar_len | output | 8 | Beats per burst minus one |
| ar_size | output | 3 | Log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, incrementing |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted by memory |
| r_data | input | DATA_W | Read beat data |
| r_last | input | 1 | Last beat of the burst |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Engine accepts read beats |
| m_tdata | output | DATA_W | Stream data |
| m_tvalid | output | 1 | Stream data valid |
| m_tready | input | 1 | Stream sink ready |

## Verification
A wrong burst index shows at the ports on the very next request. The request address is off by a multiple of 128 bytes, and every one of the 16 stream words that follow carries the wrong value. A bad wrap comparison shows within `wrap_idx`+1 bursts, either through a skipped slot or through status that does not match the completed-burst count. A miscounted FIFO level shows under a stalled sink as a third request while fewer than 16 slots are free, or as a permanent stall. A broken pointer shows as a repeated, missing or reordered stream word as soon as that entry is popped.

// File: rtl/msr_pkg.sv
package msr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // read engine phases
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_DATA = 2'd2
  } rd_phase_t;

  localparam logic [1:0] BURST_TYPE_INCR = 2'b01;
endpackage

// File: rtl/msr_fifo.sv
module msr_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] free_cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] store [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic [AW:0]  used;

  assign used     = wr_q - rd_q;
  assign empty    = (used == '0);
  assign free_cnt = CW'(DEPTH) - used;
  assign head     = store[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q[AW-1:0]] <= push_data;
  end
endmodule

// File: rtl/msr_burst_index.sv
module msr_burst_index #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] wrap_at,
  output logic [IDX_W-1:0] idx
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (step)
      idx <= (idx >= wrap_at) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/msr_rd_ctrl.sv
module msr_rd_ctrl
  import msr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int SHIFT     = 7,
  parameter int BURST_LEN = 16,
  parameter int CW        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CW-1:0]     free_cnt,
  input  logic              ar_ready,
  input  logic              r_valid,
  input  logic              r_last,
  output logic              ar_valid,
  output logic [ADDR_W-1:0] ar_addr,
  output logic              r_ready,
  output logic              burst_done
);
  timeunit 1ns;
  timeprecision 1ps;

  rd_phase_t phase_q;
  logic      room_ok;

  assign room_ok    = (free_cnt >= CW'(BURST_LEN));
  assign ar_valid   = (phase_q == RD_ADDR);
  assign r_ready    = (phase_q == RD_DATA);
  assign burst_done = r_ready && r_valid && r_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= RD_IDLE;
      ar_addr <= '0;
    end else begin
      unique case (phase_q)
        RD_IDLE: if (room_ok) begin
          phase_q <= RD_ADDR;
          ar_addr <= base_addr + (ADDR_W'(idx) << SHIFT);
        end
        RD_ADDR: if (ar_ready) phase_q <= RD_DATA;
        RD_DATA: if (burst_done) phase_q <= RD_IDLE;
        default: phase_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_stream_reader.sv
module mem_stream_reader
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 16,
  parameter int BURST_LEN  = 16,
  parameter int FIFO_DEPTH = 32,
  localparam int BEAT_B    = DATA_W / 8,
  localparam int SHIFT     = $clog2(BURST_LEN * BEAT_B),
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  wrap_idx,
  output logic [IDX_W-1:0]  burst_idx,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic              ar_valid,
  input  logic              ar_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  input  logic              r_valid,
  output logic              r_ready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          fifo_empty;
  logic [CW-1:0] fifo_free;
  logic          step;

  assign ar_len   = 8'(BURST_LEN - 1);
  assign ar_size  = 3'($clog2(BEAT_B));
  assign ar_burst = BURST_TYPE_INCR;
  assign m_tvalid = !fifo_empty;

  msr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (r_valid && r_ready),
    .push_data (r_data),
    .pop       (m_tvalid && m_tready),
    .head      (m_tdata),
    .empty     (fifo_empty),
    .free_cnt  (fifo_free)
  );

  msr_rd_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(SHIFT),
    .BURST_LEN(BURST_LEN), .CW(CW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_addr  (base_addr),
    .idx        (burst_idx),
    .free_cnt   (fifo_free),
    .ar_ready   (ar_ready),
    .r_valid    (r_valid),
    .r_last     (r_last),
    .ar_valid   (ar_valid),
    .ar_addr    (ar_addr),
    .r_ready    (r_ready),
    .burst_done (step)
  );

  msr_burst_index #(.IDX_W(IDX_W)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .wrap_at (wrap_idx),
    .idx     (burst_idx)
  );
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int DATA_W     = 64,
  parameter int BURST_LEN  = 16,
  parameter int FIFO_DEPTH = 32,
  localparam int SHIFT     = $clog2(BURST_LEN * DATA_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic [IDX_W-1:0]  wrap_idx,
  input logic [IDX_W-1:0]  burst_idx,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic [2:0]        ar_size,
  input logic [1:0]        ar_burst,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic              r_last,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tvalid,
  input logic              m_tready
);
  timeunit 1ns;
  timeprecision 1ps;

  int occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + ((r_valid && r_ready) ? 1 : 0) - ((m_tvalid && m_tready) ? 1 : 0);
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_valid) |-> occ <= FIFO_DEPTH - BURST_LEN);

  p_ar_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_len == 8'(BURST_LEN - 1)) && (ar_size == 3'd3) && (ar_burst == 2'b01));

  p_ar_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_valid) |-> ar_addr == $past(base_addr) + (ADDR_W'($past(burst_idx)) << SHIFT));

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && r_last) |=>
      burst_idx == (($past(burst_idx) >= $past(wrap_idx)) ? '0 : $past(burst_idx) + 1'b1));

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_valid && r_ready && r_last) |=> $stable(burst_idx));

  p_single_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_valid && r_ready));

  p_rready_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> r_ready);

  p_rready_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && r_last) |=> !r_ready);

  p_ar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> ar_valid && $stable(ar_addr));

  p_stream_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata));

  p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ >= 0 && occ <= FIFO_DEPTH);

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> !ar_valid && !r_ready && !m_tvalid && burst_idx == '0);
endmodule

bind mem_stream_reader msr_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
  .BURST_LEN(BURST_LEN), .FIFO_DEPTH(FIFO_DEPTH)
) u_msr_checker (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .wrap_idx(wrap_idx),
  .burst_idx(burst_idx), .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
  .ar_burst(ar_burst), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
  .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
);

// File: tb/mem_stream_reader_bench.sv
module mem_stream_reader_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] wrap_idx = '0;
  logic [15:0] burst_idx;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst;
  logic        ar_valid;
  logic        ar_ready = 1'b0;
  logic [63:0] r_data = '0;
  logic        r_last = 1'b0;
  logic        r_valid = 1'b0;
  logic        r_ready;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;

  always #10 clk = ~clk;

  mem_stream_reader u_mem_stream_reader (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .wrap_idx(wrap_idx),
    .burst_idx(burst_idx), .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
    .ar_burst(ar_burst), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_data(r_data), .r_last(r_last), .r_valid(r_valid), .r_ready(r_ready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_word(input logic [31:0] a);
    return {a, a ^ 32'hC3C3_5A5A};
  endfunction

  function automatic logic [31:0] slot_addr(input int k);
    return base_addr + 32'(128 * (k % (int'(wrap_idx) + 1)));
  endfunction

  // bus agent state
  int ar_cnt = 0, rd_cnt = 0, ar_limit = 0, beats_left = 0, tick = 0;
  int tmode = 0, pop_budget = 0;
  bit gaps = 0;
  logic [31:0] beat_addr = '0, ar_seen = '0;

  initial begin
    forever begin
      bit hs_ar, hs_r, hs_t;
      @(negedge clk);
      hs_ar = rst_n && ar_valid && ar_ready;
      hs_r  = rst_n && r_valid && r_ready;
      hs_t  = rst_n && m_tvalid && m_tready;
      if (rst_n && ar_valid) chk(beats_left == 0, "R6", "request while burst open", 1, 0);
      if (rst_n && (r_ready || beats_left > 0))
        chk(r_ready == (beats_left > 0), "R7", "r_ready window", longint'(r_ready), longint'(beats_left > 0));
      if (hs_ar) begin
        chk(ar_addr == slot_addr(ar_cnt), "R3", "request address", ar_addr, slot_addr(ar_cnt));
        chk(ar_len == 8'd15 && ar_size == 3'd3 && ar_burst == 2'b01, "R2", "burst fields",
            {ar_len, ar_size, ar_burst}, {8'd15, 3'd3, 2'b01});
        chk(burst_idx == 16'(ar_cnt % (int'(wrap_idx) + 1)), "R5", "status at request",
            burst_idx, ar_cnt % (int'(wrap_idx) + 1));
        ar_seen = ar_addr;
        ar_cnt++;
      end
      if (hs_t) begin
        logic [31:0] ea;
        ea = slot_addr(rd_cnt / 16) + 32'(8 * (rd_cnt % 16));
        chk(m_tdata == beat_word(ea), "R9", "stream word order", m_tdata, beat_word(ea));
        rd_cnt++;
        if (pop_budget > 0) pop_budget--;
      end
      @(posedge clk);
      #1;
      tick++;
      if (!rst_n) begin
        ar_cnt = 0; rd_cnt = 0; beats_left = 0;
      end else begin
        if (hs_ar) begin beats_left = 16; beat_addr = ar_seen; end
        if (hs_r) begin beats_left--; beat_addr += 8; end
      end
      r_valid  = (beats_left > 0) && !(gaps && (tick % 3 == 0));
      r_data   = beat_word(beat_addr);
      r_last   = (beats_left == 1);
      ar_ready = (ar_cnt < ar_limit) && !(gaps && (tick % 2 == 0));
      m_tready = (tmode == 0) ? 1'b1 : (tmode == 1) ? (tick % 3 == 0) : (pop_budget > 0);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ar_valid && !m_tvalid && !r_ready, "R11", "outputs low in reset",
        {ar_valid, m_tvalid, r_ready}, 0);
    chk(burst_idx == 0, "R11", "index cleared", burst_idx, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_words(input int target);
    int t = 0;
    while (rd_cnt < target && t < 20000) begin @(negedge clk); t++; end
    chk(rd_cnt == target, "R10", "words delivered", rd_cnt, target);
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] wrap;
    logic [7:0]  nb;
    logic [1:0]  tm;
    logic        gp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h1000_0000, 16'd3, 8'd10, 2'd0, 1'b0},
    '{32'h0000_4000, 16'd0, 8'd3,  2'd1, 1'b1},
    '{32'h2000_0080, 16'd5, 8'd8,  2'd1, 1'b0},
    '{32'h0000_0000, 16'd1, 8'd5,  2'd0, 1'b1},
    '{32'hFFFF_FF00, 16'd2, 8'd4,  2'd0, 1'b0}
  };

  initial begin
    foreach (VECS[i]) begin
      base_addr = VECS[i].base;
      wrap_idx  = VECS[i].wrap;
      tmode     = int'(VECS[i].tm);
      gaps      = VECS[i].gp;
      ar_limit  = int'(VECS[i].nb);
      do_reset();
      wait_words(int'(VECS[i].nb) * 16);
      repeat (5) @(negedge clk);
      chk(ar_cnt == int'(VECS[i].nb), "R6", "bursts requested", ar_cnt, VECS[i].nb);
      chk(!m_tvalid && rd_cnt == int'(VECS[i].nb) * 16, "R2", "exactly 16 beats per burst",
          rd_cnt, int'(VECS[i].nb) * 16);
      // R4 / R5: index counts completed bursts modulo wrap+1
      chk(burst_idx == 16'(int'(VECS[i].nb) % (int'(VECS[i].wrap) + 1)), "R4", "index after run",
          burst_idx, int'(VECS[i].nb) % (int'(VECS[i].wrap) + 1));
    end

    // stalled sink: FIFO space rule (R1, R10)
    base_addr = 32'h8000_0000; wrap_idx = 16'd7;
    tmode = 2; gaps = 0; ar_limit = 100;
    do_reset();
    repeat (200) @(negedge clk);
    chk(ar_cnt == 2, "R1", "bursts with stalled sink", ar_cnt, 2);
    chk(m_tvalid && !ar_valid, "R1", "full FIFO holds request", {m_tvalid, ar_valid}, 2'b10);
    @(posedge clk); #3 pop_budget = 15;
    repeat (100) @(negedge clk);
    chk(rd_cnt == 15, "R10", "budgeted pops", rd_cnt, 15);
    chk(ar_cnt == 2, "R1", "15 free is not enough", ar_cnt, 2);
    @(posedge clk); #3 pop_budget = 1;
    repeat (100) @(negedge clk);
    chk(ar_cnt == 3, "R1", "16 free allows request", ar_cnt, 3);
    chk(burst_idx == 16'd3, "R5", "status after three bursts", burst_idx, 3);

    // reset with a loaded FIFO (R11)
    do_reset();
    @(negedge clk);
    chk(burst_idx == 0 && !r_ready, "R11", "state after mid-run reset", burst_idx, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule